// File: doc/BRIEF.md
# NAND Flash Bus Cycle Engine

This block sits between a simple register bus and the pins of an 8-bit NAND flash device. Each register access is turned into one or more timed flash bus cycles. A write to the command register gives one cycle with the command latch high. A write to the address register gives one cycle with the address latch high. A write to the data register gives write-strobe cycles, and a read of the data register gives read-strobe cycles. A 32-bit data access is split into four byte cycles, least significant byte first.

Each byte cycle has three timed parts: latch setup before the strobe falls, strobe low, and hold after the strobe rises. Each part takes a 3-bit count from the control register, and a count N gives N+1 clocks. The bus access waits (ready low) until the last byte cycle ends. Software can poll the synchronized ready/busy level in the status register. It can also use a sticky interrupt flag that is set on a rising edge of ready/busy.

Register map (bus_addr): 0 control, 1 command, 2 address, 3 data, 4 status. The control register holds chip enable in bit 0, setup count in bits 3:1, low count in bits 6:4 and hold count in bits 9:7. The status register holds the synchronized R/nB level in bit 0 and the sticky flag in bit 1.

Top module: `nand_cycle_engine`

## Requirements
- R1: After reset, nWE and nRE are high, CLE, ALE, I/O enable, irq and bus_ready are low, nCE is high, and the control register reads as 0.
- R2: A write to address 1 gives exactly one nWE low pulse with CLE high, ALE low, I/O enable high and bus_wdata[7:0] on the I/O lines.
- R3: A write to address 2 gives exactly one nWE low pulse with ALE high, CLE low, I/O enable high and bus_wdata[7:0] on the I/O lines.
- R4: A write to address 3 gives exactly four nWE pulses with CLE and ALE low. The bytes go out in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: A read of address 3 gives four nRE pulses with I/O enable low. The byte sampled at the first pulse returns in bus_rdata[7:0] and the byte sampled at the fourth pulse returns in bus_rdata[31:24].
- R6: With setup count S (control bits 3:1), the latch and I/O enable are active for S+1 clocks before nWE falls.
- R7: With low count L (control bits 6:4), every nWE or nRE low pulse lasts L+1 clocks.
- R8: With hold count H (control bits 9:7), I/O enable and the active latch stay high for H+1 clocks after nWE rises.
- R9: bus_ready is a single-cycle pulse. A control or status access completes in 1 clock. A flash access of n bytes completes 1+n*(S+L+H+4) clocks after acceptance starts.
- R10: nCE is the inverse of control bit 0. It changes only when the control register is written and stays put during flash cycles.
- R11: Status bit 1 (also driven on irq) is set by a rising edge of R/nB and stays set. Writing 1 to status bit 1 clears it, and writing 0 leaves it unchanged. Status bit 0 reads the synchronized R/nB level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access complete pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nce | output | 1 | Chip enable, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_io_out | output | 8 | I/O output byte |
| nand_io_in | input | 8 | I/O input byte |
| nand_io_oe | output | 1 | I/O output enable |
| nand_rnb | input | 1 | Ready/busy from the device |
| irq | output | 1 | Sticky ready interrupt |

## Verification
If the phase counter loads or counts down wrongly, the next strobe has the wrong low width, setup or hold. The monitor catches this when that strobe ends. If the byte index is wrong, the wrong byte shows on the I/O lines at the next write strobe, or bus_rdata is wrong when the read completes. A wrong byte count shows as a latency error on bus_ready and as a leftover or missing scoreboard entry. Errors in the flag logic show on irq within three clocks of an R/nB edge or of a status write.

// File: rtl/nand_pkg.sv
// Shared types and constants for the NAND bus cycle engine.
// Assumes an 8-bit device and 3-bit phase counts.
package nand_pkg;
    localparam int CNT_W  = 3;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 1 + 3 * CNT_W;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CMD    = 3'd1;
    localparam logic [ADDR_W-1:0] REG_ADDR   = 3'd2;
    localparam logic [ADDR_W-1:0] REG_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] REG_STATUS = 3'd4;

    typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WR, OP_RD} op_e;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] setup;
        logic             ce;
    } ctrl_t;
endpackage

// File: rtl/nand_phase_timer.sv
// Runs one byte cycle as setup, strobe-low and hold phases.
// A count of N lasts N+1 clocks. Assumes the counts are stable while busy.
module nand_phase_timer
    import nand_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] setup_cnt,
    input  logic [W-1:0] low_cnt,
    input  logic [W-1:0] hold_cnt,
    output phase_e       phase,
    output logic         low_last,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Phase sequencing with per-phase down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SETUP;
                    cnt_q <= setup_cnt;
                end
                PH_SETUP: if (cnt_q == '0) begin
                    phase <= PH_LOW;
                    cnt_q <= low_cnt;
                end else cnt_q <= cnt_q - 1'b1;
                PH_LOW: if (cnt_q == '0) begin
                    phase <= PH_HOLD;
                    cnt_q <= hold_cnt;
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (cnt_q == '0) begin
                    phase <= PH_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Last-clock markers for read capture and byte completion.
    assign low_last = (phase == PH_LOW)  && (cnt_q == '0);
    assign done     = (phase == PH_HOLD) && (cnt_q == '0);
endmodule

// File: rtl/nand_data_lane.sv
// Holds the data word as byte lanes: loaded whole on a write,
// filled one byte at a time on a read. Lane 0 is bits IO_W-1:0.
module nand_data_lane #(
    parameter int DATA_W = 32,
    parameter int IO_W   = 8,
    localparam int BYTES = DATA_W / IO_W,
    localparam int IDX_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              cap,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IO_W-1:0]   cap_byte,
    output logic [DATA_W-1:0] word,
    output logic [IO_W-1:0]   sel_byte
);
    logic [IO_W-1:0] lane_q [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // One byte lane: bulk load or single-byte capture.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (load)
                lane_q[g] <= load_word[g*IO_W +: IO_W];
            else if (cap && (idx == IDX_W'(g)))
                lane_q[g] <= cap_byte;
        end
        assign word[g*IO_W +: IO_W] = lane_q[g];
    end

    assign sel_byte = lane_q[idx];
endmodule

// File: rtl/nand_rnb_monitor.sv
// Synchronizes R/nB and keeps a sticky flag set on its rising edge.
// Set wins over a same-cycle clear. The sync chain resets to ready.
module nand_rnb_monitor #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rnb_async,
    input  logic clr,
    output logic rnb_level,
    output logic flag
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;

    // Synchronizer chain and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], rnb_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise      = sync_q[STAGES-1] & ~prev_q;
    assign rnb_level = sync_q[STAGES-1];

    // Sticky flag: set on rise, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (rise) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/nand_cycle_engine.sv
// Turns register-bus accesses into timed NAND bus cycles.
// Assumes bus_valid is held until bus_ready, and the control register
// is written only while no flash access runs.
module nand_cycle_engine
    import nand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_W   = 8,
    localparam int BYTES = DATA_W / IO_W,
    localparam int IDX_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_nce,
    output logic              nand_nre,
    output logic              nand_nwe,
    output logic [IO_W-1:0]   nand_io_out,
    input  logic [IO_W-1:0]   nand_io_in,
    output logic              nand_io_oe,
    input  logic              nand_rnb,
    output logic              irq
);
    ctrl_t            ctrl_q;
    op_e              op_q;
    logic             active_q;
    logic [IO_W-1:0]  byte_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    phase_e           phase;
    logic             low_last, done;
    logic             accept, flash_req, clr_flag, lane_load;
    logic             rnb_level, flag;
    logic [DATA_W-1:0] word;
    logic [IO_W-1:0]   lane_byte;

    assign accept    = bus_valid && !bus_ready && !active_q;
    assign flash_req = (bus_write && (bus_addr == REG_CMD || bus_addr == REG_ADDR
                                      || bus_addr == REG_DATA))
                    || (!bus_write && bus_addr == REG_DATA);
    assign clr_flag  = accept && bus_write && (bus_addr == REG_STATUS) && bus_wdata[1];
    assign lane_load = accept && bus_write && (bus_addr == REG_DATA);

    nand_phase_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(active_q && phase == PH_IDLE),
        .setup_cnt(ctrl_q.setup), .low_cnt(ctrl_q.low), .hold_cnt(ctrl_q.hold),
        .phase(phase), .low_last(low_last), .done(done)
    );

    nand_data_lane #(.DATA_W(DATA_W), .IO_W(IO_W)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .load(lane_load), .load_word(bus_wdata),
        .cap(low_last && op_q == OP_RD), .idx(idx_q), .cap_byte(nand_io_in),
        .word(word), .sel_byte(lane_byte)
    );

    nand_rnb_monitor #(.STAGES(2)) u_rnb (
        .clk(clk), .rst_n(rst_n), .rnb_async(nand_rnb), .clr(clr_flag),
        .rnb_level(rnb_level), .flag(flag)
    );

    // Access acceptance, flash op bookkeeping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            op_q      <= OP_CMD;
            active_q  <= 1'b0;
            byte_q    <= '0;
            idx_q     <= '0;
            last_q    <= '0;
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= 1'b0;
            if (accept) begin
                if (flash_req) begin
                    active_q <= 1'b1;
                    byte_q   <= bus_wdata[IO_W-1:0];
                    idx_q    <= '0;
                    if (bus_addr == REG_DATA) begin
                        op_q   <= bus_write ? OP_WR : OP_RD;
                        last_q <= IDX_W'(BYTES - 1);
                    end else begin
                        op_q   <= (bus_addr == REG_CMD) ? OP_CMD : OP_ADDR;
                        last_q <= '0;
                    end
                end else begin
                    bus_ready <= 1'b1;
                    bus_rdata <= '0;
                    if (bus_addr == REG_CTRL) begin
                        if (bus_write) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                        bus_rdata <= DATA_W'(ctrl_q);
                    end else if (bus_addr == REG_STATUS) begin
                        bus_rdata <= DATA_W'({flag, rnb_level});
                    end
                end
            end else if (active_q && done) begin
                if (idx_q == last_q) begin
                    active_q  <= 1'b0;
                    bus_ready <= 1'b1;
                    bus_rdata <= (op_q == OP_RD) ? word : '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Pin decode from op and phase.
    always_comb begin
        nand_cle    = active_q && (op_q == OP_CMD)  && (phase != PH_IDLE);
        nand_ale    = active_q && (op_q == OP_ADDR) && (phase != PH_IDLE);
        nand_io_oe  = active_q && (op_q != OP_RD)   && (phase != PH_IDLE);
        nand_nwe    = !(active_q && (op_q != OP_RD) && (phase == PH_LOW));
        nand_nre    = !(active_q && (op_q == OP_RD) && (phase == PH_LOW));
        nand_io_out = (op_q == OP_WR) ? lane_byte : byte_q;
        nand_nce    = !ctrl_q.ce;
        irq         = flag;
    end
endmodule

// File: rtl/nand_cycle_engine_chk.sv
// Pin- and bus-level properties of the cycle engine, bound to the top.
module nand_cycle_engine_chk
    import nand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_nce,
    input logic              nand_nre,
    input logic              nand_nwe,
    input logic [IO_W-1:0]   nand_io_out,
    input logic [IO_W-1:0]   nand_io_in,
    input logic              nand_io_oe,
    input logic              nand_rnb,
    input logic              irq
);
    // R2/R3: only one latch at a time.
    a_r2_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R7: strobes never overlap.
    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_nwe && !nand_nre));
    // R5: no drive while reading.
    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_nre |-> !nand_io_oe);
    // R6: a write strobe falls only after a setup clock with drive on.
    a_r6_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_nwe) |-> $past(nand_io_oe));
    // R9: ready is a single-cycle pulse.
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    // R10: chip enable moves only on a control write.
    a_r10_nce_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == REG_CTRL) |=> $stable(nand_nce));
    // R11: the flag stays set unless a clearing write arrives.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_valid && bus_write && bus_addr == REG_STATUS && bus_wdata[1]))
        |=> irq);
endmodule

bind nand_cycle_engine nand_cycle_engine_chk #(.DATA_W(DATA_W), .IO_W(IO_W)) u_chk (.*);

// File: tb/nand_cycle_engine_test.sv
module nand_cycle_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ready, nand_cle, nand_ale, nand_nce, nand_nre, nand_nwe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_io_oe, irq;
    logic        nand_rnb = 1'b1;

    int tests = 0, failed = 0, cyc = 0;
    int ts = 0, tl = 0, th = 0;

    typedef struct { int kind; logic [7:0] b; int s, l, h; } exp_t;
    exp_t sq[$];

    logic [7:0] flash_bytes [4];
    int rd_i = 0;
    assign nand_io_in = flash_bytes[rd_i % 4];

    always #2 clk = ~clk;

    nand_cycle_engine uut (.*);

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            tests++; failed++;
            $display("FAIL watchdog: actual %0d expected < %0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    // Monitor: measures each strobe and compares with the scoreboard.
    int pre = 0, wlow = 0, whold = 0, rlow = 0;
    int cur_kind, cur_setup;
    logic [7:0] cur_byte;
    logic cur_oe, cur_nce, latch_bad = 1'b0;

    function automatic string tag(int k);
        return (k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : "R5";
    endfunction

    task automatic finish_write();
        exp_t e;
        if (sq.size() == 0) begin chk(0, "R4", "unexpected write strobe", 1, 0); return; end
        e = sq.pop_front();
        chk(cur_kind == e.kind, tag(e.kind), "strobe kind", cur_kind, e.kind);
        chk(cur_byte == e.b, tag(e.kind), "io byte", cur_byte, e.b);
        chk(cur_oe == 1'b1, tag(e.kind), "io enable", cur_oe, 1);
        chk(cur_nce == 1'b0, "R10", "nce during cycle", cur_nce, 0);
        chk(cur_setup == e.s + 1, "R6", "setup clocks", cur_setup, e.s + 1);
        chk(wlow == e.l + 1, "R7", "nwe low clocks", wlow, e.l + 1);
        chk(whold == e.h + 1, "R8", "hold clocks", whold, e.h + 1);
        chk(!latch_bad, "R8", "latch during hold", latch_bad, 0);
    endtask

    task automatic finish_read();
        exp_t e;
        if (sq.size() == 0) begin chk(0, "R5", "unexpected read strobe", 1, 0); return; end
        e = sq.pop_front();
        chk(e.kind == 3, "R5", "strobe kind", 3, e.kind);
        chk(rlow == e.l + 1, "R7", "nre low clocks", rlow, e.l + 1);
    endtask

    always @(negedge clk) if (rst_n) begin
        if (!nand_nwe) begin
            if (wlow == 0) begin
                cur_kind  = nand_cle ? 0 : nand_ale ? 1 : 2;
                cur_byte  = nand_io_out;
                cur_oe    = nand_io_oe;
                cur_nce   = nand_nce;
                cur_setup = pre;
            end
            wlow++;
        end else if (wlow != 0) begin
            if (nand_io_oe) begin
                whold++;
                if ((cur_kind == 0 && !nand_cle) || (cur_kind == 1 && !nand_ale)) latch_bad = 1'b1;
            end else begin
                finish_write();
                wlow = 0; whold = 0; pre = 0; latch_bad = 1'b0;
            end
        end else begin
            pre = nand_io_oe ? pre + 1 : 0;
        end
        if (!nand_nre) rlow++;
        else if (rlow != 0) begin
            finish_read();
            rlow = 0;
            rd_i++;
        end
    end

    // One register access; lat counts clock edges up to the ready pulse.
    task automatic xfer(logic [2:0] a, logic w, logic [31:0] d,
                        output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!bus_ready);
        rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_timing(int s, int l, int h);
        logic [31:0] rd; int lat;
        ts = s; tl = l; th = h;
        xfer(3'd0, 1'b1, {22'd0, 3'(h), 3'(l), 3'(s), 1'b1}, rd, lat);
        chk(lat == 1, "R9", "control write latency", lat, 1);
        chk(nand_nce == 1'b0, "R10", "nce after enable", nand_nce, 0);
    endtask

    task automatic push(int k, logic [7:0] b);
        exp_t e;
        e.kind = k; e.b = b; e.s = ts; e.l = tl; e.h = th;
        sq.push_back(e);
    endtask

    task automatic do_cmd(int k, logic [7:0] b);
        logic [31:0] rd; int lat;
        push(k, b);
        xfer((k == 0) ? 3'd1 : 3'd2, 1'b1, {24'hABCDEF, b}, rd, lat);
        chk(lat == ts + tl + th + 5, "R9", "single byte latency", lat, ts + tl + th + 5);
    endtask

    task automatic do_wr(logic [31:0] w);
        logic [31:0] rd; int lat;
        for (int i = 0; i < 4; i++) push(2, w[8*i +: 8]);
        xfer(3'd3, 1'b1, w, rd, lat);
        chk(lat == 1 + 4 * (ts + tl + th + 4), "R9", "word write latency", lat,
            1 + 4 * (ts + tl + th + 4));
    endtask

    task automatic do_rd(logic [31:0] w);
        logic [31:0] rd; int lat;
        for (int i = 0; i < 4; i++) begin flash_bytes[i] = w[8*i +: 8]; push(3, 8'h00); end
        rd_i = 0;
        xfer(3'd3, 1'b0, 32'd0, rd, lat);
        chk(rd == w, "R5", "read word", rd, w);
        chk(lat == 1 + 4 * (ts + tl + th + 4), "R9", "word read latency", lat,
            1 + 4 * (ts + tl + th + 4));
    endtask

    initial begin
        logic [31:0] rd; int lat;
        for (int i = 0; i < 4; i++) flash_bytes[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pin and bus state after reset
        chk(nand_nwe && nand_nre, "R1", "strobes idle", {nand_nwe, nand_nre}, 2'b11);
        chk(!nand_cle && !nand_ale && !nand_io_oe, "R1", "latches and enable",
            {nand_cle, nand_ale, nand_io_oe}, 0);
        chk(nand_nce && !irq && !bus_ready, "R1", "nce irq ready",
            {nand_nce, irq, bus_ready}, 3'b100);
        xfer(3'd0, 1'b0, 32'd0, rd, lat);
        chk(rd == 0, "R1", "control reset value", rd, 0);

        set_timing(1, 2, 0);
        do_cmd(0, 8'h70);
        do_cmd(1, 8'h12);
        do_wr(32'hA1B2C3D4);
        do_rd(32'h44332211);

        set_timing(0, 0, 3);
        do_cmd(0, 8'h80);
        do_wr(32'h0F1E2D3C);
        do_rd(32'hDEADBEEF);

        set_timing(7, 7, 7);
        do_cmd(1, 8'hFF);
        do_wr(32'h00FF5AA5);

        // R10: disabling chip enable
        xfer(3'd0, 1'b1, 32'd0, rd, lat);
        chk(nand_nce == 1'b1, "R10", "nce after disable", nand_nce, 1);

        // R11: ready/busy level and sticky flag
        @(negedge clk) nand_rnb = 1'b0;
        repeat (5) @(negedge clk);
        xfer(3'd4, 1'b0, 32'd0, rd, lat);
        chk(rd == 32'd0, "R11", "status while busy", rd, 0);
        chk(lat == 1, "R9", "status latency", lat, 1);
        @(negedge clk) nand_rnb = 1'b1;
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R11", "irq after rising edge", irq, 1);
        xfer(3'd4, 1'b0, 32'd0, rd, lat);
        chk(rd == 32'd3, "R11", "status after edge", rd, 3);
        xfer(3'd4, 1'b1, 32'd0, rd, lat);
        xfer(3'd4, 1'b0, 32'd0, rd, lat);
        chk(rd == 32'd3 && irq, "R11", "write 0 keeps flag", rd, 3);
        xfer(3'd4, 1'b1, 32'd2, rd, lat);
        xfer(3'd4, 1'b0, 32'd0, rd, lat);
        chk(rd == 32'd1, "R11", "write 1 clears flag", rd, 1);
        chk(irq == 1'b0, "R11", "irq cleared", irq, 0);

        repeat (4) @(negedge clk);
        chk(sq.size() == 0, "R4", "leftover expected strobes", sq.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule